// File: doc/BRIEF.md
# Little-Endian Word Stack Engine

This block pushes and pops 16-bit words on a stack kept in byte-addressed RAM. The RAM is reached through a port one byte wide. A 16-bit stack pointer addresses the most recently pushed byte. The stack grows toward lower addresses. A push first lowers the pointer by two and then writes the word. The low byte goes to the pointer address and the high byte to the pointer address plus one. A pop reads the two bytes at the same addresses and then raises the pointer by two.

A third command saves an interrupt context. It captures six context words when it is accepted and pushes them one after another with no further command. The pushes run in this order: program counter, four general registers, then the flag word.

Commands enter through a valid/ready port. `cmd_ready` is high only while the engine is idle. A command offered while `cmd_ready` is low is not held or queued: it is dropped, and the sticky `err_o` flag is set. The initiator should therefore wait for ready before it raises valid. Popped words leave on `pop_valid`/`pop_data` as a one-cycle pulse with no back-pressure. `mem_rdata` is combinational: it must present the byte at `mem_addr` in the same cycle.

Top module: `stack_engine`

## Requirements
- R1: Reset state. After reset `sp_o` equals the parameter STACK_BASE (default 0x0000), and `busy_o`, `err_o`, `underflow_o`, `pop_valid` and `mem_en` are 0.
- R2: Push (cmd_op = 2'b00). `sp_o` drops by 2 on the acceptance edge. In the next cycle the byte `cmd_wdata[7:0]` is written to address `sp_o`. In the cycle after that, `cmd_wdata[15:8]` is written to `sp_o`+1.
- R3: Pop (cmd_op = 2'b01). In the first cycle the low byte is read from `sp_o`, and in the second the high byte from `sp_o`+1. On the edge that ends the second cycle, `pop_data` = {high, low} with `pop_valid` high for one cycle, and `sp_o` rises by 2.
- R4: Words come back in last-in first-out order.
- R5: Context save (cmd_op = 2'b10). All six slots of `ctx_words` are captured on acceptance; slot k sits in bits [16k+15:16k]. Slot 0 is the program counter, slots 1 to 4 are the general registers and slot 5 is the flags. Slot k is written at the entry pointer minus 2(k+1), so `sp_o` ends 12 lower. Later changes to `ctx_words` have no effect on the saved words.
- R6: Each word takes exactly two memory cycles. `busy_o` is high for 2 cycles after a push or pop and for 12 cycles after a context save; `cmd_ready` is its inverse.
- R7: A command offered while busy is ignored: memory, pointer and outputs are unaffected. The sticky `err_o` flag is set and stays set until reset.
- R8: The pointer wraps modulo 2^16. A push from 0x0000 gives 0xFFFE and writes addresses 0xFFFE and 0xFFFF.
- R9: A pop while `sp_o` equals STACK_BASE makes no memory access, leaves `sp_o` unchanged and gives no `pop_valid`. It sets the sticky `underflow_o` flag.
- R10: The reserved code cmd_op = 2'b11 performs no access and leaves `sp_o` unchanged. It sets `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_op | input | 2 | 00 push, 01 pop, 10 context save, 11 reserved |
| cmd_wdata | input | 16 | Word to push |
| ctx_words | input | 96 | Six context words, slot k in bits [16k+15:16k] |
| pop_valid | output | 1 | One-cycle pulse with a popped word |
| pop_data | output | 16 | Popped word |
| sp_o | output | 16 | Current stack pointer |
| busy_o | output | 1 | Memory sequence in progress |
| err_o | output | 1 | Sticky: command dropped or reserved |
| underflow_o | output | 1 | Sticky: pop on an empty stack |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, combinational from mem_addr |

## Verification
The bench drives a command at a falling edge, so acceptance falls on the next rising edge. The new pointer of a push can be read at the falling edge after that. The bench counts falling edges with `busy_o` high to confirm two per word, or twelve for a context save. A pop's word and pulse are due at the first falling edge with `busy_o` low, and the bench reads them there. A refused or reserved command never raises `busy_o`, so its flags and pointer are checked one falling edge after it is offered.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_CTX  = 2'b10,
    OP_RSVD = 2'b11
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_HI,
    ST_RD_LO,
    ST_RD_HI
  } stk_state_e;
endpackage

// File: rtl/stack_ptr.sv
module stack_ptr #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec,
  input  logic              inc,
  output logic [ADDR_W-1:0] sp
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp <= RESET_VAL;
    else if (dec) sp <= sp - STEP;
    else if (inc) sp <= sp + STEP;
  end
endmodule

// File: rtl/ctx_snap.sv
module ctx_snap #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_SLOTS = 6,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [NUM_SLOTS*WORD_W-1:0] words_in,
  input  logic [IDX_W-1:0]            idx,
  output logic [WORD_W-1:0]           word_out
);
  logic [WORD_W-1:0] slots [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    slots[g] <= '0;
      else if (load) slots[g] <= words_in[g*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    word_out = '0;
    if ({{(32-IDX_W){1'b0}}, idx} < NUM_SLOTS) word_out = slots[idx];
  end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned NUM_CTX = 6,
  parameter int unsigned IDX_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_op,
  input  logic [2*BYTE_W-1:0]   cmd_wdata,
  input  logic                  stack_empty,
  input  logic [ADDR_W-1:0]     sp,
  input  logic [2*BYTE_W-1:0]   slot_word,
  output logic [IDX_W-1:0]      slot_idx,
  output logic                  snap_load,
  output logic                  sp_dec,
  output logic                  sp_inc,
  output logic                  busy,
  output logic                  err,
  output logic                  underflow,
  output logic                  pop_valid,
  output logic [2*BYTE_W-1:0]   pop_data,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [BYTE_W-1:0]     mem_wdata,
  input  logic [BYTE_W-1:0]     mem_rdata
);
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CTX - 1);

  stk_state_e        state, state_nx;
  logic              in_ctx;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] wr_word;
  logic [BYTE_W-1:0] lo_q;
  logic              idle, accept, go_push, go_pop, go_ctx, refuse_pop;
  logic              ctx_more, hi_phase;

  assign idle       = (state == ST_IDLE);
  assign accept     = cmd_valid && idle;
  assign go_push    = accept && (cmd_op == OP_PUSH);
  assign go_ctx     = accept && (cmd_op == OP_CTX);
  assign go_pop     = accept && (cmd_op == OP_POP) && !stack_empty;
  assign refuse_pop = accept && (cmd_op == OP_POP) && stack_empty;
  assign ctx_more   = (state == ST_WR_HI) && in_ctx && (slot_idx != LAST_IDX);

  assign snap_load = go_ctx;
  assign sp_dec    = go_push || go_ctx || ctx_more;
  assign sp_inc    = (state == ST_RD_HI);
  assign busy      = !idle;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: begin
        if (go_push || go_ctx) state_nx = ST_WR_LO;
        else if (go_pop)       state_nx = ST_RD_LO;
      end
      ST_WR_LO: state_nx = ST_WR_HI;
      ST_WR_HI: state_nx = ctx_more ? ST_WR_LO : ST_IDLE;
      ST_RD_LO: state_nx = ST_RD_HI;
      ST_RD_HI: state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      in_ctx    <= 1'b0;
      slot_idx  <= '0;
      word_q    <= '0;
      lo_q      <= '0;
      err       <= 1'b0;
      underflow <= 1'b0;
      pop_valid <= 1'b0;
      pop_data  <= '0;
    end else begin
      state     <= state_nx;
      pop_valid <= (state == ST_RD_HI);
      if (go_push) word_q <= cmd_wdata;
      if (go_ctx) begin
        in_ctx   <= 1'b1;
        slot_idx <= '0;
      end else if (ctx_more) begin
        slot_idx <= slot_idx + IDX_W'(1);
      end else if (state == ST_WR_HI) begin
        in_ctx <= 1'b0;
      end
      if (state == ST_RD_LO) lo_q <= mem_rdata;
      if (state == ST_RD_HI) pop_data <= {mem_rdata, lo_q};
      if ((cmd_valid && !idle) || (accept && cmd_op == OP_RSVD)) err <= 1'b1;
      if (refuse_pop) underflow <= 1'b1;
    end
  end

  assign hi_phase  = (state == ST_WR_HI) || (state == ST_RD_HI);
  assign wr_word   = in_ctx ? slot_word : word_q;
  assign mem_en    = !idle;
  assign mem_we    = (state == ST_WR_LO) || (state == ST_WR_HI);
  assign mem_addr  = hi_phase ? sp + ADDR_W'(1) : sp;
  assign mem_wdata = hi_phase ? wr_word[WORD_W-1:BYTE_W] : wr_word[BYTE_W-1:0];
endmodule

// File: rtl/stack_engine.sv
module stack_engine #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned NUM_CTX = 6,
  parameter logic [ADDR_W-1:0] STACK_BASE = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic [1:0]                    cmd_op,
  input  logic [2*BYTE_W-1:0]           cmd_wdata,
  input  logic [NUM_CTX*2*BYTE_W-1:0]   ctx_words,
  output logic                          pop_valid,
  output logic [2*BYTE_W-1:0]           pop_data,
  output logic [ADDR_W-1:0]             sp_o,
  output logic                          busy_o,
  output logic                          err_o,
  output logic                          underflow_o,
  output logic                          mem_en,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [BYTE_W-1:0]             mem_wdata,
  input  logic [BYTE_W-1:0]             mem_rdata
);
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam int unsigned IDX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

  logic              sp_dec, sp_inc, snap_load;
  logic [IDX_W-1:0]  slot_idx;
  logic [WORD_W-1:0] slot_word;

  stack_ptr #(.ADDR_W(ADDR_W), .RESET_VAL(STACK_BASE)) ptr_i (
    .clk(clk), .rst_n(rst_n), .dec(sp_dec), .inc(sp_inc), .sp(sp_o)
  );

  ctx_snap #(.WORD_W(WORD_W), .NUM_SLOTS(NUM_CTX), .IDX_W(IDX_W)) snap_i (
    .clk(clk), .rst_n(rst_n), .load(snap_load), .words_in(ctx_words),
    .idx(slot_idx), .word_out(slot_word)
  );

  stack_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_CTX(NUM_CTX), .IDX_W(IDX_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .stack_empty(sp_o == STACK_BASE), .sp(sp_o),
    .slot_word(slot_word), .slot_idx(slot_idx), .snap_load(snap_load),
    .sp_dec(sp_dec), .sp_inc(sp_inc), .busy(busy_o), .err(err_o),
    .underflow(underflow_o), .pop_valid(pop_valid), .pop_data(pop_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign cmd_ready = !busy_o;
endmodule

// File: rtl/stack_engine_chk.sv
module stack_engine_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [ADDR_W-1:0] sp_o,
  input logic              busy_o,
  input logic              err_o,
  input logic              underflow_o,
  input logic              pop_valid,
  input logic              mem_en,
  input logic              mem_we
);
  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'b00) |=> (sp_o == $past(sp_o) - ADDR_W'(2)));

  // R3
  pop_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> ($past(mem_en) && !$past(mem_we) && !busy_o));

  // R6
  write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> busy_o);

  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (err_o && $stable(sp_o)));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R9
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> underflow_o);
endmodule

bind stack_engine stack_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .sp_o(sp_o), .busy_o(busy_o), .err_o(err_o),
  .underflow_o(underflow_o), .pop_valid(pop_valid), .mem_en(mem_en),
  .mem_we(mem_we)
);

// File: tb/stack_engine_tb.sv
module stack_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [15:0] cmd_wdata;
  logic [95:0] ctx_words;
  logic        pop_valid;
  logic [15:0] pop_data;
  logic [15:0] sp_o;
  logic        busy_o, err_o, underflow_o;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0]  mem [256];
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .ctx_words(ctx_words),
    .pop_valid(pop_valid), .pop_data(pop_data), .sp_o(sp_o),
    .busy_o(busy_o), .err_o(err_o), .underflow_o(underflow_o),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) if (mem_en && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[7:0]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    cmd_valid = 1'b0; cmd_op = 2'b00; cmd_wdata = '0; ctx_words = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input logic [15:0] d, output int bc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    bc = 0;
    while (busy_o) begin bc++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk(sp_o == 16'h0000, "R1 sp", sp_o, 0);
    chk(!busy_o && cmd_ready && !err_o && !underflow_o && !pop_valid && !mem_en,
        "R1 flags", {busy_o, err_o, underflow_o, pop_valid, mem_en}, 0);
  endtask

  task automatic t_push_pop();
    int bc;
    issue(2'b00, 16'hA1B2, bc);
    chk(sp_o == 16'hFFFE, "R8 wrap sp", sp_o, 16'hFFFE);
    chk(mem[8'hFE] == 8'hB2 && mem[8'hFF] == 8'hA1, "R2 byte order",
        {mem[8'hFF], mem[8'hFE]}, 16'hA1B2);
    chk(bc == 2, "R6 push busy", bc, 2);
    issue(2'b00, 16'hC3D4, bc);
    chk(sp_o == 16'hFFFC, "R2 second push sp", sp_o, 16'hFFFC);
    mem[8'hFC] = 8'h5A;
    issue(2'b01, 16'h0, bc);
    chk(pop_valid && pop_data == 16'hC35A, "R3 pop data", pop_data, 16'hC35A);
    chk(sp_o == 16'hFFFE, "R3 pop sp", sp_o, 16'hFFFE);
    chk(bc == 2, "R6 pop busy", bc, 2);
    @(negedge clk);
    chk(!pop_valid, "R3 one-cycle pulse", pop_valid, 0);
    issue(2'b01, 16'h0, bc);
    chk(pop_valid && pop_data == 16'hA1B2, "R4 lifo", pop_data, 16'hA1B2);
    chk(sp_o == 16'h0000, "R8 wrap back", sp_o, 0);
  endtask

  task automatic t_underflow();
    int bc;
    issue(2'b01, 16'h0, bc);
    chk(bc == 0 && !pop_valid, "R9 no access", {bc[7:0], pop_valid}, 0);
    chk(underflow_o && sp_o == 16'h0000, "R9 flag", {underflow_o, sp_o}, 32'h10000);
  endtask

  task automatic t_reserved();
    int bc;
    chk(!err_o, "R10 err clear before", err_o, 0);
    issue(2'b11, 16'hFFFF, bc);
    chk(err_o && bc == 0 && sp_o == 16'h0000, "R10 reserved",
        {err_o, bc[7:0], sp_o}, 32'h1000000);
  endtask

  task automatic t_collision();
    int bc;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_wdata = 16'h1111;
    @(negedge clk);
    cmd_wdata = 16'h2222;
    chk(busy_o && !err_o, "R7 busy before drop", {busy_o, err_o}, 2'b10);
    @(negedge clk);
    cmd_valid = 1'b0;
    bc = 0;
    while (busy_o) begin bc++; @(negedge clk); end
    chk(err_o, "R7 err set", err_o, 1);
    chk(sp_o == 16'hFFFE, "R7 one push only", sp_o, 16'hFFFE);
    chk(mem[8'hFE] == 8'h11 && mem[8'hFF] == 8'h11, "R7 data untouched",
        {mem[8'hFF], mem[8'hFE]}, 16'h1111);
    @(negedge clk);
    chk(err_o, "R7 err sticky", err_o, 1);
  endtask

  task automatic t_context();
    logic [95:0] ctx;
    int bc;
    ctx = {16'hF005, 16'hD004, 16'hC003, 16'hB002, 16'hA001, 16'h1234};
    @(negedge clk);
    ctx_words = ctx; cmd_valid = 1'b1; cmd_op = 2'b10;
    @(negedge clk);
    cmd_valid = 1'b0; ctx_words = '1;
    bc = 0;
    while (busy_o) begin bc++; @(negedge clk); end
    chk(bc == 12, "R6 ctx busy", bc, 12);
    chk(sp_o == 16'hFFF4, "R5 ctx sp", sp_o, 16'hFFF4);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] a;
      a = 8'hFE - 8'(2 * k);
      chk({mem[a + 8'd1], mem[a]} == ctx[k*16 +: 16], "R5 slot order",
          {mem[a + 8'd1], mem[a]}, ctx[k*16 +: 16]);
    end
    for (int k = 5; k >= 0; k--) begin
      issue(2'b01, 16'h0, bc);
      chk(pop_valid && pop_data == ctx[k*16 +: 16], "R4 ctx unwind",
          pop_data, ctx[k*16 +: 16]);
    end
    chk(sp_o == 16'h0000, "R5 ctx unwind sp", sp_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    do_reset();
    t_reset();
    t_push_pop();
    t_underflow();
    t_reserved();
    do_reset();
    t_reset();
    t_collision();
    do_reset();
    t_context();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule